// File: doc/BRIEF.md
# Programmable Half-Integer Clock Divider

This block derives a slower clock from a reference clock. The division ratio can be any whole number from 2 to 16, or any of the half-integer values 1.5, 2.5, 3.5, 4.5, 5.5, 6.5 and 7.5. An optional halving stage can be switched in ahead of the divider, which doubles the overall ratio. The output is built from flops on both edges of the reference. Every output period is therefore a whole number of reference half-periods. Each period begins on a rising reference edge whenever the total count of half-periods is even.

Software or a sequencer places a ratio code and the halving selection on the inputs and pulses the reload strobe for one cycle. An illegal code is dropped. A legal code waits until the output period in progress has finished. The divider then starts the next period at the new ratio and pulses a one-cycle completion flag. Reset drives the output low and restarts the count, so the first rising edge of the output falls on the first reference rising edge after reset is released.

Top module: `clkdiv_top`

## Requirements
- R1: `ratioCode` holds twice the division ratio. The legal codes are every even value from 4 to 32 and every odd value from 3 to 15. With `preHalve` low, the output period is `ratioCode` half-periods of `clk`.
- R2: With `preHalve` high at reload, the output period is 2 × `ratioCode` half-periods of `clk`.
- R3: With H half-periods per output period, the output is high for floor(H/2) half-periods at the start of each period and low for the rest. Even H therefore gives an exact 50 % duty cycle.
- R4: A reload whose code is illegal (odd and above 15, below 3, or above 32) is ignored. No completion pulse follows, and the output period does not change.
- R5: A new ratio takes effect only at a period boundary that falls on a `clk` rising edge. Every output period is a complete period of either the old ratio or the new one.
- R6: `ratioDone` is high for exactly one `clk` cycle after each accepted ratio change, and is low at all other times.
- R7: While `rstN` is low, `clkOut` and `ratioDone` are low. Reset returns the ratio to 2 (code 4, halving off).
- R8: After reset is released, the first rising edge of `clkOut` occurs at the first `clk` rising edge. When H is even, every rising edge of `clkOut` lies on a `clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| ratioCode | input | 6 | Twice the requested division ratio |
| preHalve | input | 1 | Applies the divide-by-two input stage when high at reload |
| reload | input | 1 | One-cycle strobe that samples ratioCode and preHalve |
| clkOut | output | 1 | Divided clock |
| ratioDone | output | 1 | One-cycle pulse when a new ratio has taken effect |

## Verification
The bench targets the smallest odd ratio (1.5). A design with the wrong half-period bookkeeping produces a 2-cycle or 1-cycle period there, or a pulse one half-period too wide. It also targets ratio changes made while the old period is still running. An early switch would leave a period whose length matches neither ratio. Further cases are the largest count, code 32 with halving (64 half-periods), which would overflow a counter that is too narrow, and illegal codes on both sides of the legal range. A divider that accepts an illegal code would change its period or raise the completion flag. The last case is a reset in mid-period followed by release, where a stale phase would put the first rising edge late or on a falling reference edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W       = 6;
  localparam int HALF_W       = CODE_W + 1;
  localparam int MIN_CODE     = 3;
  localparam int MAX_CODE     = 32;
  localparam int MAX_ODD_CODE = 15;
  localparam int RESET_HALVES = 4;

  typedef struct packed {
    logic              commit;
    logic [HALF_W-1:0] halves;
  } divStrobe_t;
endpackage

// File: rtl/clkdiv_ctl.sv
module clkdiv_ctl
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic              preHalve,
  input  logic              reload,
  input  logic              wrapSoon,
  output divStrobe_t        strobe,
  output logic              ratioDone
);
  logic              pendValid;
  logic [HALF_W-1:0] pendHalves;
  logic              codeLegal;
  logic [HALF_W-1:0] reqHalves;

  always_comb begin
    codeLegal = (ratioCode >= CODE_W'(MIN_CODE)) && (ratioCode <= CODE_W'(MAX_CODE)) &&
                (!ratioCode[0] || (ratioCode <= CODE_W'(MAX_ODD_CODE)));
    reqHalves = preHalve ? {ratioCode, 1'b0} : {1'b0, ratioCode};
  end

  assign strobe.commit = pendValid && wrapSoon;
  assign strobe.halves = pendHalves;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendHalves <= HALF_W'(RESET_HALVES);
      ratioDone  <= 1'b0;
    end else begin
      ratioDone <= strobe.commit;
      if (reload && codeLegal) begin
        pendValid  <= 1'b1;
        pendHalves <= reqHalves;
      end else if (strobe.commit) begin
        pendValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  output logic              wrapSoon,
  output logic [HALF_W-1:0] activeHalves,
  output logic              clkOut
);
  localparam int SUM_W = HALF_W + 1;

  logic [HALF_W-1:0] phase;
  logic [HALF_W-1:0] highLen;
  logic [SUM_W-1:0]  phaseNext2;
  logic [SUM_W-1:0]  phaseNext1;
  logic [HALF_W-1:0] phaseAdv;
  logic [HALF_W-1:0] secondPos;
  logic              firstVal;
  logic              secondVal;
  logic              posQ;
  logic              negQ;
  logic              secondHalf;

  always_comb begin
    highLen    = activeHalves >> 1;
    phaseNext2 = SUM_W'(phase) + SUM_W'(2);
    phaseNext1 = SUM_W'(phase) + SUM_W'(1);
    wrapSoon   = (phaseNext2 == SUM_W'(activeHalves));
    phaseAdv   = (phaseNext2 >= SUM_W'(activeHalves)) ?
                 HALF_W'(phaseNext2 - SUM_W'(activeHalves)) : HALF_W'(phaseNext2);
    secondPos  = (phaseNext1 >= SUM_W'(activeHalves)) ?
                 HALF_W'(phaseNext1 - SUM_W'(activeHalves)) : HALF_W'(phaseNext1);
    firstVal   = phase < highLen;
    secondVal  = secondPos < highLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= '0;
      activeHalves <= HALF_W'(RESET_HALVES);
      posQ         <= 1'b0;
      secondHalf   <= 1'b0;
    end else begin
      phase      <= strobe.commit ? '0 : phaseAdv;
      posQ       <= firstVal ^ negQ;
      secondHalf <= secondVal;
      if (strobe.commit) activeHalves <= strobe.halves;
    end
  end

  always_ff @(negedge clk) begin
    if (!rstN) negQ <= 1'b0;
    else       negQ <= secondHalf ^ posQ;
  end

  assign clkOut = posQ ^ negQ;
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] ratioCode,
  input  logic       preHalve,
  input  logic       reload,
  output logic       clkOut,
  output logic       ratioDone
);
  divStrobe_t        strobe;
  logic              wrapSoon;
  logic [HALF_W-1:0] activeHalves;

  clkdiv_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ratioCode(ratioCode), .preHalve(preHalve),
    .reload(reload), .wrapSoon(wrapSoon), .strobe(strobe), .ratioDone(ratioDone)
  );

  clkdiv_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrapSoon(wrapSoon),
    .activeHalves(activeHalves), .clkOut(clkOut)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
  import clkdiv_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              commit,
  input logic              wrapSoon,
  input logic [HALF_W-1:0] halves,
  input logic              done
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_follows_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> done);

  assert_commit_at_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> wrapSoon);

  assert_ratio_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(halves));

  assert_legal_halves_R4: assert property (@(posedge clk) disable iff (!rstN)
    (halves >= HALF_W'(MIN_CODE)) && (halves <= HALF_W'(2 * MAX_CODE)) &&
    (!halves[0] || halves <= HALF_W'(MAX_ODD_CODE)));
endmodule

bind clkdiv_top clkdiv_checker u_chk (
  .clk(clk), .rstN(rstN), .commit(strobe.commit), .wrapSoon(wrapSoon),
  .halves(activeHalves), .done(ratioDone)
);

// File: tb/tb_clkdiv_top.sv
`timescale 1ns/1ps
module tb_clkdiv_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] ratioCode = 6'd4;
  logic       preHalve = 1'b0;
  logic       reload = 1'b0;
  logic       clkOut;
  logic       ratioDone;

  int  checks = 0;
  int  errors = 0;
  int  hOld = 4;
  int  hNew = 4;
  bit  monOn = 1'b0;
  time lastRise = 0;

  clkdiv_top dut (.clk(clk), .rstN(rstN), .ratioCode(ratioCode), .preHalve(preHalve),
                  .reload(reload), .clkOut(clkOut), .ratioDone(ratioDone));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int halvesFor(input int code, input bit pre);
    return pre ? 2 * code : code;
  endfunction

  function automatic bit legalCode(input int code);
    return code >= 3 && code <= 32 && (code % 2 == 0 || code <= 15);
  endfunction

  // R5: every period is a whole old or new period
  always @(posedge clkOut) begin
    if (monOn && lastRise != 0)
      check(($time - lastRise) == hOld * 20 / 2 || ($time - lastRise) == hNew * 20 / 2,
            "R5", "period in half-periods x10ns", longint'($time - lastRise), hNew * 10);
    lastRise = $time;
  end

  task automatic measure(input string req, input int h);
    time t1, tf, t2;
    @(posedge clkOut); t1 = $time;
    @(negedge clkOut); tf = $time;
    @(posedge clkOut); t2 = $time;
    check((t2 - t1) == h * 10, req, "period ns", longint'(t2 - t1), h * 10);
    check((tf - t1) == (h / 2) * 10, "R3", "high time ns", longint'(tf - t1), (h / 2) * 10);
    if (h % 2 == 0)
      check((t1 % 20) == 10, "R8", "rise on clk rising edge (t mod 20)", longint'(t1 % 20), 10);
  endtask

  task automatic doReset();
    time relEdge;
    monOn = 1'b0;
    lastRise = 0;
    @(negedge clk); rstN = 1'b0; reload = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(clkOut == 1'b0, "R7", "clkOut in reset", clkOut, 0);
    check(ratioDone == 1'b0, "R7", "ratioDone in reset", ratioDone, 0);
    @(negedge clk);
    hOld = 4; hNew = 4;
    monOn = 1'b1;
    rstN = 1'b1;
    relEdge = $time + 10;
    @(posedge clkOut);
    check($time == relEdge, "R8", "first rise time after reset", longint'($time), longint'(relEdge));
    measure("R7", 4);
  endtask

  task automatic setRatio(input int code, input bit pre);
    bit accept = legalCode(code);
    bit seen = 1'b0;
    int target = halvesFor(code, pre);
    @(negedge clk);
    ratioCode = 6'(code); preHalve = pre; reload = 1'b1;
    hOld = hNew;
    if (accept) hNew = target;
    @(negedge clk); reload = 1'b0;
    for (int i = 0; i < 150 && !seen; i++) begin
      if (ratioDone) seen = 1'b1;
      else @(negedge clk);
    end
    if (accept) begin
      check(seen, "R6", "completion pulse seen", seen, 1);
      @(negedge clk);
      check(ratioDone == 1'b0, "R6", "pulse width one cycle", ratioDone, 0);
      measure(pre ? "R2" : "R1", target);
    end else begin
      check(!seen, "R4", "no completion for illegal code", seen, 0);
      measure("R4", hNew);
    end
    hOld = hNew;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    doReset();
    // directed corners: R1 half-integer and integer, R2 halving
    setRatio(3, 1'b0);
    setRatio(6, 1'b0);
    setRatio(15, 1'b0);
    setRatio(32, 1'b0);
    setRatio(32, 1'b1);
    setRatio(3, 1'b1);
    setRatio(5, 1'b0);
    setRatio(4, 1'b1);
    // R4 illegal codes around the legal range
    setRatio(17, 1'b0);
    setRatio(2, 1'b0);
    setRatio(33, 1'b1);
    setRatio(31, 1'b0);
    setRatio(0, 1'b0);
    setRatio(63, 1'b0);
    // random legal mix
    for (int i = 0; i < 24; i++) begin
      int code = $urandom_range(3, 32);
      bit pre = 1'($urandom_range(0, 1));
      if (code % 2 == 1 && code > 15) code = code - 1;
      setRatio(code, pre);
    end
    // R7 reset in the middle of a long period
    setRatio(30, 1'b0);
    repeat (7) @(negedge clk);
    doReset();
    setRatio(7, 1'b0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule